// File: doc/BRIEF.md
# Programmable Clock-Enable Ratio Generator

This block derives three periodic clock-enable strobes from a single base clock: one for the processor domain, one for the bus domain and one for the peripheral domain. Each strobe is high for exactly one base cycle out of every N base cycles. Logic in each domain advances only on its enable, so it runs at 1/N of the base rate without a second clock tree. N can be any integer in the ratio table, odd or even.

A single 16-bit frequency-control register, written through a simple write port, selects the three ratios. Three packed 3-bit codes in the register are looked up in two fixed ratio tables. Bit 10 of a written word is a lock bit: when it is set, the word is stored and reads back, but the ratios in use stay as they were. A newly accepted ratio takes effect at the next terminal count of its domain's counter, so no enable period is ever cut short. The ratio currently in force in each domain is output as a 4-bit binary number for dependent logic such as serial line-rate dividers and timer prescalers.

Top module: `clk_ratio_gen`

## Requirements
- R1: After reset, the register reads 0x0E0A and the ratios in force are processor 1, bus 2, peripheral 4.
- R2: Register bits 8:6 select the processor ratio. Codes 0 to 4 give 1, 2, 3, 4 and 5.
- R3: Register bits 5:3 select the bus ratio, using the same code-to-ratio mapping as the processor field.
- R4: Register bits 2:0 select the peripheral ratio. Codes 0 to 3 give 2, 3, 4 and 6.
- R5: Out-of-range codes give a ratio of 8. These are codes 5, 6 and 7 in the processor and bus fields, and codes 4 to 7 in the peripheral field.
- R6: A write whose bit 10 is 1 leaves all three ratios unchanged. A write whose bit 10 is 0 requests the ratios decoded from the written word.
- R7: rdData returns the last written word from the cycle after the write, whether or not the ratio update was blocked.
- R8: Each enable is a one-cycle pulse every N base cycles, where N is that domain's ratio. With a ratio of 1 the enable stays high. After reset, the first pulse falls in cycle N-1, counting the first cycle after reset as cycle 0.
- R9: A requested ratio takes effect at the next pulse of that domain. The period that is running when the request arrives completes at the old ratio, and the periods after that pulse use the new ratio.
- R10: cpuRatio, busRatio and perRatio report, in binary, the ratio that times each domain's current period. Each output changes only in the cycle after a pulse of its domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe for the control register |
| wrData | input | 16 | Word to write; bit 10 is the lock bit |
| rdData | output | 16 | Current control register contents |
| cpuEn | output | 1 | Processor-domain clock enable |
| busEn | output | 1 | Bus-domain clock enable |
| perEn | output | 1 | Peripheral-domain clock enable |
| cpuRatio | output | 4 | Processor ratio in force |
| busRatio | output | 4 | Bus ratio in force |
| perRatio | output | 4 | Peripheral ratio in force |

## Verification
A write at a clock edge is visible on rdData one cycle later. The requested ratio is held from that edge onward and is loaded at the first domain pulse that follows, so cpuRatio, busRatio and perRatio change one cycle after that pulse. The enables are combinational from the counters and are due in the cycle in which a counter reaches its terminal count. The bench runs a cycle-by-cycle arithmetic model that advances on the same edge as the design. It compares every output at the falling edge, once the state has settled and before the next inputs take effect. Pulse counts over a 120-cycle window, which is a multiple of every ratio, give an independent check of each ratio after the change has settled.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;

  localparam int REG_W    = 16;
  localparam int FIELD_W  = 3;
  localparam int RATIO_W  = 4;
  localparam int N_DOM    = 3;
  localparam int LOCK_BIT = 10;
  localparam int CPU_LSB  = 6;
  localparam int BUS_LSB  = 3;
  localparam int PER_LSB  = 0;
  localparam logic [REG_W-1:0] RESET_VAL = 16'h0E0A;

  typedef enum int {
    DOM_CPU = 0,
    DOM_BUS = 1,
    DOM_PER = 2
  } domain_e;

  typedef logic [RATIO_W-1:0] ratio_t;

  // Request from control to datapath: ratios to load at next terminal count.
  typedef struct packed {
    ratio_t [N_DOM-1:0] ratio;
  } ratioCmd_t;

  // Core/bus table: 1,2,3,4,5 then saturate at 8.
  function automatic ratio_t coreRatio(input logic [FIELD_W-1:0] code);
    case (code)
      3'd0:    return ratio_t'(1);
      3'd1:    return ratio_t'(2);
      3'd2:    return ratio_t'(3);
      3'd3:    return ratio_t'(4);
      3'd4:    return ratio_t'(5);
      default: return ratio_t'(8);
    endcase
  endfunction

  // Peripheral table: 2,3,4,6 then saturate at 8.
  function automatic ratio_t periRatio(input logic [FIELD_W-1:0] code);
    case (code)
      3'd0:    return ratio_t'(2);
      3'd1:    return ratio_t'(3);
      3'd2:    return ratio_t'(4);
      3'd3:    return ratio_t'(6);
      default: return ratio_t'(8);
    endcase
  endfunction

  function automatic ratioCmd_t decodeWord(input logic [REG_W-1:0] word);
    ratioCmd_t c;
    c.ratio[DOM_CPU] = coreRatio(word[CPU_LSB +: FIELD_W]);
    c.ratio[DOM_BUS] = coreRatio(word[BUS_LSB +: FIELD_W]);
    c.ratio[DOM_PER] = periRatio(word[PER_LSB +: FIELD_W]);
    return c;
  endfunction

  function automatic logic legalRatio(input ratio_t r);
    return (r >= ratio_t'(1)) && (r <= ratio_t'(6) || r == ratio_t'(8));
  endfunction

endpackage

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl
  import clk_ratio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output ratioCmd_t        cmd
);

  logic [REG_W-1:0] regVal;
  ratioCmd_t        cmdReg;
  logic             acceptWr;

  assign acceptWr = wrEn && !wrData[LOCK_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      regVal <= RESET_VAL;
    end else if (wrEn) begin
      regVal <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdReg <= decodeWord(RESET_VAL);
    end else if (acceptWr) begin
      cmdReg <= decodeWord(wrData);
    end
  end

  assign rdData = regVal;
  assign cmd    = cmdReg;

  AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrData[LOCK_BIT]) |=> $stable(cmd)); // R6

  AST_READBACK: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> (rdData == $past(wrData))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> ($stable(rdData) && $stable(cmd))); // R7

endmodule

// File: rtl/clk_ratio_dp.sv
module clk_ratio_dp
  import clk_ratio_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ratioCmd_t          cmd,
  output logic [N_DOM-1:0]   enOut,
  output ratio_t [N_DOM-1:0] ratioOut
);

  localparam ratioCmd_t RESET_CMD = decodeWord(RESET_VAL);

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    ratio_t cnt;
    ratio_t act;
    logic   term;

    assign term = (cnt == act - ratio_t'(1));

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt <= '0;
        act <= RESET_CMD.ratio[d];
      end else if (term) begin
        cnt <= '0;
        act <= cmd.ratio[d];
      end else begin
        cnt <= cnt + ratio_t'(1);
      end
    end

    assign enOut[d]    = term;
    assign ratioOut[d] = act;

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
      enOut[d] |=> (!enOut[d] || ratioOut[d] == ratio_t'(1))); // R8

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt < act); // R8

    AST_SWITCH_AT_TERMINAL: assert property (@(posedge clk) disable iff (rst)
      !enOut[d] |=> $stable(ratioOut[d])); // R9

    AST_LOAD_REQUEST: assert property (@(posedge clk) disable iff (rst)
      enOut[d] |=> (ratioOut[d] == $past(cmd.ratio[d]))); // R10

    AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (rst)
      legalRatio(ratioOut[d])); // R5
  end

endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen
  import clk_ratio_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  output logic               cpuEn,
  output logic               busEn,
  output logic               perEn,
  output logic [RATIO_W-1:0] cpuRatio,
  output logic [RATIO_W-1:0] busRatio,
  output logic [RATIO_W-1:0] perRatio
);

  ratioCmd_t          cmd;
  logic [N_DOM-1:0]   enVec;
  ratio_t [N_DOM-1:0] ratioVec;

  clk_ratio_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (wrEn),
    .wrData (wrData),
    .rdData (rdData),
    .cmd    (cmd)
  );

  clk_ratio_dp dp_i (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .enOut    (enVec),
    .ratioOut (ratioVec)
  );

  assign cpuEn    = enVec[DOM_CPU];
  assign busEn    = enVec[DOM_BUS];
  assign perEn    = enVec[DOM_PER];
  assign cpuRatio = ratioVec[DOM_CPU];
  assign busRatio = ratioVec[DOM_BUS];
  assign perRatio = ratioVec[DOM_PER];

endmodule

// File: tb/clk_ratio_gen_tb_top.sv
module clk_ratio_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        cpuEn, busEn, perEn;
  logic [3:0]  cpuRatio, busRatio, perRatio;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model state, indexed 0=cpu 1=bus 2=peripheral
  int          mCnt[3];
  int          mAct[3];
  int          mTgt[3];
  logic [15:0] mReg;

  always #2 clk = ~clk;

  clk_ratio_gen dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .cpuEn(cpuEn), .busEn(busEn), .perEn(perEn),
    .cpuRatio(cpuRatio), .busRatio(busRatio), .perRatio(perRatio)
  );

  function automatic int expCore(input int code);
    return (code < 5) ? code + 1 : 8;
  endfunction

  function automatic int expPeri(input int code);
    if (code < 3) return code + 2;
    if (code == 3) return 6;
    return 8;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int enOf(input int d);
    return (d == 0) ? int'(cpuEn) : (d == 1) ? int'(busEn) : int'(perEn);
  endfunction

  function automatic int ratioOf(input int d);
    return (d == 0) ? int'(cpuRatio) : (d == 1) ? int'(busRatio) : int'(perRatio);
  endfunction

  // One base cycle: compare outputs to model, apply inputs, advance model.
  task automatic cycle(input bit we, input logic [15:0] d);
    for (int k = 0; k < 3; k++) begin
      chk(enOf(k) == int'(mCnt[k] == mAct[k] - 1), "R8 enable timing",
          enOf(k), int'(mCnt[k] == mAct[k] - 1));
      chk(ratioOf(k) == mAct[k], "R9/R10 ratio in force", ratioOf(k), mAct[k]);
    end
    chk(rdData == mReg, "R7 readback", rdData, mReg);
    wrEn = we;
    wrData = d;
    @(posedge clk);
    for (int k = 0; k < 3; k++) begin
      if (mCnt[k] == mAct[k] - 1) begin
        mAct[k] = mTgt[k];
        mCnt[k] = 0;
      end else begin
        mCnt[k]++;
      end
    end
    if (we) begin
      mReg = d;
      if (!d[10]) begin
        mTgt[0] = expCore(int'(d[8:6]));
        mTgt[1] = expCore(int'(d[5:3]));
        mTgt[2] = expPeri(int'(d[2:0]));
      end
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 16'h0);
  endtask

  // Count pulses over 120 cycles (multiple of every ratio) and compare.
  task automatic pulseCount(input int e0, input int e1, input int e2, input string req);
    int cnt[3];
    cnt = '{0, 0, 0};
    for (int i = 0; i < 120; i++) begin
      for (int k = 0; k < 3; k++) cnt[k] += enOf(k);
      cycle(1'b0, 16'h0);
    end
    chk(cnt[0] == 120 / e0, {req, " cpu pulse count"}, cnt[0], 120 / e0);
    chk(cnt[1] == 120 / e1, {req, " bus pulse count"}, cnt[1], 120 / e1);
    chk(cnt[2] == 120 / e2, {req, " peri pulse count"}, cnt[2], 120 / e2);
  endtask

  task automatic writeAndCheck(input int cc, input int bc, input int pc, input bit lock);
    logic [15:0] w;
    int e0, e1, e2;
    w = 16'h0;
    w[8:6] = 3'(cc);
    w[5:3] = 3'(bc);
    w[2:0] = 3'(pc);
    w[10]  = lock;
    w[15]  = 1'b1;
    if (lock) begin
      e0 = mTgt[0]; e1 = mTgt[1]; e2 = mTgt[2];
    end else begin
      e0 = expCore(cc); e1 = expCore(bc); e2 = expPeri(pc);
    end
    cycle(1'b1, w);
    chk(rdData == w, "R7 readback after write", rdData, w);
    idle(10);
    chk(int'(cpuRatio) == e0, lock ? "R6 cpu held" : "R2 cpu table", cpuRatio, e0);
    chk(int'(busRatio) == e1, lock ? "R6 bus held" : "R3 bus table", busRatio, e1);
    chk(int'(perRatio) == e2, lock ? "R6 peri held" : "R4 peri table", perRatio, e2);
    if (!lock && (cc > 4 || bc > 4 || pc > 3))
      chk((cc > 4 ? int'(cpuRatio) == 8 : 1) && (bc > 4 ? int'(busRatio) == 8 : 1) &&
          (pc > 3 ? int'(perRatio) == 8 : 1), "R5 saturation", perRatio, 8);
    pulseCount(e0, e1, e2, "R8");
  endtask

  initial begin
    mReg = 16'h0E0A;
    mTgt = '{1, 2, 4};
    mAct = '{1, 2, 4};
    mCnt = '{0, 0, 0};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(rdData == 16'h0E0A, "R1 reset register", rdData, 16'h0E0A);
    chk(cpuRatio == 4'd1, "R1 reset cpu ratio", cpuRatio, 1);
    chk(busRatio == 4'd2, "R1 reset bus ratio", busRatio, 2);
    chk(perRatio == 4'd4, "R1 reset peri ratio", perRatio, 4);
    chk(perEn == 1'b0 && busEn == 1'b0 && cpuEn == 1'b1, "R8 first cycle enables",
        {cpuEn, busEn, perEn}, 3'b100);
    idle(20);
    // Sweep every code in every field, unlocked
    for (int c = 0; c < 8; c++) writeAndCheck(c, c, c, 1'b0);
    for (int c = 0; c < 8; c++) writeAndCheck(c, (c + 3) % 8, (c + 5) % 8, 1'b0);
    // Locked writes must not change ratios (R6)
    writeAndCheck(2, 4, 3, 1'b0);
    for (int c = 0; c < 8; c++) writeAndCheck(7 - c, c, (c + 1) % 8, 1'b1);
    // Back-to-back ratio changes mid-period (R9), checked cycle by cycle
    for (int c = 0; c < 8; c++) begin
      cycle(1'b1, {5'd0, 1'b0, 1'b0, 3'(c), 3'(7 - c), 3'(c)});
      idle(c + 1);
      cycle(1'b1, {5'd0, 1'b0, 1'b0, 3'(7 - c), 3'(c), 3'((c + 2) % 8)});
      idle(3);
    end
    idle(20);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule